// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block advances the time-of-day and calendar registers of a real-time clock once per second. On each one-second tick it steps seconds, minutes and hours and carries into the day of week, day of month, month and two-digit year. Month lengths follow the calendar, and February gets a 29th day in years divisible by four. All seven registers hold either packed BCD or plain binary, and hours may be kept in 24-hour form or in 12-hour form with a meridiem flag.

Three configuration bits are loaded through a configuration strobe and are not touched by reset: the encoding, the hour format and a daylight-saving enable. With daylight saving on, the engine skips the hour from 2 AM to 3 AM on the first Sunday of April. On the last Sunday of October it repeats the 1 AM hour once. Software loads the time one register at a time through a write port. A write that arrives in the same cycle as a tick is applied in the cycle after the update. A one-cycle pulse marks each finished update.

Top module: `caltime_step`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00, and day of week, day of month and month read 0x01. The update pulse is low.
- R2: With the encoding bit at 0, every register holds packed BCD (tens digit in bits 7:4). A tick at 23:59:59 on Saturday (day of week 7) 31 December, year 99, gives 00:00:00 on day of week 1, the 1st of January, year 00.
- R3: With the encoding bit at 1, registers hold plain binary. Months 4, 6, 9 and 11 have 30 days, February has 28 days, or 29 days when the year is divisible by 4, and the other months have 31 days.
- R4: With the hour-format bit at 0, bit 7 of the hours register is 1 for PM and 0 for AM, and bits 6:0 count 12, 1 to 11. The flag flips when the hour steps from 11 to 12, and the day advances when 11 PM becomes 12 AM.
- R5: With daylight saving enabled, a tick at 01:59:59 on a Sunday (day of week 1) with day of month 7 or less in April gives 03:00:00. The same tick on a later Sunday in April gives 02:00:00.
- R6: With daylight saving enabled, the first tick at 01:59:59 on a Sunday in October with day of month 25 or more gives 01:00:00. When the repeated hour later reaches 01:59:59, the next tick gives 02:00:00.
- R7: A daylight-saving jump happens only if at least two normal updates followed the last software write. After a write at 01:59:58, the second tick gives 02:00:00.
- R8: With the daylight-saving bit at 0, the April trigger tick gives 02:00:00.
- R9: The update pulse is high for exactly the one cycle after each tick edge.
- R10: A write that coincides with a tick takes effect one cycle after that tick's update. The update itself is computed from the old value. Write select codes: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 ignored.
- R11: The three configuration bits keep their value across a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the time registers |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| cfg_we | input | 1 | Loads the three configuration bits |
| cfg_bin_in | input | 1 | Encoding: 0 packed BCD, 1 binary |
| cfg_h24_in | input | 1 | Hour format: 0 twelve-hour, 1 twenty-four-hour |
| cfg_dst_in | input | 1 | Daylight-saving enable |
| wr_en | input | 1 | Time register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data in the current encoding |
| t_sec | output | 8 | Seconds |
| t_min | output | 8 | Minutes |
| t_hour | output | 8 | Hours (bit 7 is the PM flag in 12-hour mode) |
| t_wday | output | 8 | Day of week, 1 to 7, Sunday is 1 |
| t_mday | output | 8 | Day of month |
| t_mon | output | 8 | Month |
| t_year | output | 8 | Year, 00 to 99 |
| upd_done | output | 1 | One-cycle pulse after each update |

## Verification
The range assertions assume that software only loads legal values in the current encoding. They also assume that ticks are never on consecutive cycles and that the configuration stays fixed while time runs. The bench writes the configuration first and loads only valid calendar values. It leaves at least one idle cycle between ticks, and it changes the configuration only between scenarios, reloading the time each time it does.

// File: rtl/caltime_step.sv
module caltime_step #(
  parameter int DST_GUARD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       cfg_we,
  input  logic       cfg_bin_in,
  input  logic       cfg_h24_in,
  input  logic       cfg_dst_in,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] t_sec,
  output logic [7:0] t_min,
  output logic [7:0] t_hour,
  output logic [7:0] t_wday,
  output logic [7:0] t_mday,
  output logic [7:0] t_mon,
  output logic [7:0] t_year,
  output logic       upd_done
);
  localparam int CW = $clog2(DST_GUARD + 1);
  localparam logic [CW-1:0] GUARD = CW'(DST_GUARD);

  function automatic logic [7:0] dec(input logic [7:0] v, input logic b);
    return b ? v : ({4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]});
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] v, input logic b);
    logic [7:0] q, r;
    q = v / 8'd10;
    r = v - q * 8'd10;
    return b ? v : {q[3:0], r[3:0]};
  endfunction

  logic [7:0] tr [7];
  logic       cfg_bin, cfg_h24, cfg_dst;
  logic [CW-1:0] ok_cnt;
  logic       fall_done;
  logic       pend_v;
  logic [2:0] pend_sel;
  logic [7:0] pend_data;

  logic [7:0] c_s, c_m, c_h, c_wd, c_md, c_mo, c_yr, h12raw, mlen;
  logic [7:0] n_s, n_m, n_h, n_wd, n_md, n_mo, n_yr, hh, n_hreg;
  logic       at_159, spring, fall, day_wrap;

  always_ff @(posedge clk)
    if (cfg_we) {cfg_bin, cfg_h24, cfg_dst} <= {cfg_bin_in, cfg_h24_in, cfg_dst_in};

  always_comb begin
    c_s  = dec(tr[0], cfg_bin);
    c_m  = dec(tr[1], cfg_bin);
    c_wd = tr[3];
    c_md = dec(tr[4], cfg_bin);
    c_mo = dec(tr[5], cfg_bin);
    c_yr = dec(tr[6], cfg_bin);
    h12raw = dec({1'b0, tr[2][6:0]}, cfg_bin);
    if (cfg_h24) c_h = dec(tr[2], cfg_bin);
    else         c_h = (h12raw == 8'd12 ? 8'd0 : h12raw) + (tr[2][7] ? 8'd12 : 8'd0);
  end

  always_comb
    case (c_mo)
      8'd2:                         mlen = (c_yr[1:0] == 2'd0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:      mlen = 8'd30;
      default:                      mlen = 8'd31;
    endcase

  assign at_159 = (c_h == 8'd1) && (c_m == 8'd59) && (c_s == 8'd59);
  assign spring = cfg_dst && (ok_cnt == GUARD) && at_159 && (c_mo == 8'd4)
                  && (c_wd == 8'd1) && (c_md <= 8'd7);
  assign fall   = cfg_dst && (ok_cnt == GUARD) && at_159 && (c_mo == 8'd10)
                  && (c_wd == 8'd1) && (c_md >= 8'd25) && !fall_done;

  always_comb begin
    n_s = c_s; n_m = c_m; n_h = c_h; n_wd = c_wd;
    n_md = c_md; n_mo = c_mo; n_yr = c_yr;
    day_wrap = 1'b0;
    if (spring) begin
      n_s = 8'd0; n_m = 8'd0; n_h = 8'd3;
    end else if (fall) begin
      n_s = 8'd0; n_m = 8'd0; n_h = 8'd1;
    end else if (c_s < 8'd59) begin
      n_s = c_s + 8'd1;
    end else begin
      n_s = 8'd0;
      if (c_m < 8'd59) n_m = c_m + 8'd1;
      else begin
        n_m = 8'd0;
        if (c_h < 8'd23) n_h = c_h + 8'd1;
        else begin
          n_h = 8'd0;
          day_wrap = 1'b1;
          n_wd = (c_wd >= 8'd7) ? 8'd1 : c_wd + 8'd1;
          if (c_md < mlen) n_md = c_md + 8'd1;
          else begin
            n_md = 8'd1;
            if (c_mo < 8'd12) n_mo = c_mo + 8'd1;
            else begin
              n_mo = 8'd1;
              n_yr = (c_yr >= 8'd99) ? 8'd0 : c_yr + 8'd1;
            end
          end
        end
      end
    end
    hh = (n_h >= 8'd12) ? n_h - 8'd12 : n_h;
    if (hh == 8'd0) hh = 8'd12;
    n_hreg = cfg_h24 ? enc(n_h, cfg_bin) : {n_h >= 8'd12, enc(hh, cfg_bin)[6:0]};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tr[0] <= 8'd0; tr[1] <= 8'd0; tr[2] <= 8'd0; tr[3] <= 8'd1;
      tr[4] <= 8'd1; tr[5] <= 8'd1; tr[6] <= 8'd0;
      upd_done  <= 1'b0;
      ok_cnt    <= '0;
      fall_done <= 1'b0;
      pend_v    <= 1'b0;
      pend_sel  <= 3'd0;
      pend_data <= 8'd0;
    end else begin
      upd_done <= sec_tick;
      if (sec_tick) begin
        tr[0] <= enc(n_s, cfg_bin);
        tr[1] <= enc(n_m, cfg_bin);
        tr[2] <= n_hreg;
        tr[3] <= n_wd;
        tr[4] <= enc(n_md, cfg_bin);
        tr[5] <= enc(n_mo, cfg_bin);
        tr[6] <= enc(n_yr, cfg_bin);
        ok_cnt <= (spring || fall) ? '0 : ((ok_cnt == GUARD) ? ok_cnt : ok_cnt + 1'b1);
        if (fall) fall_done <= 1'b1;
        else if (day_wrap) fall_done <= 1'b0;
        if (wr_en && wr_sel != 3'd7) begin
          pend_v <= 1'b1; pend_sel <= wr_sel; pend_data <= wr_data;
        end
      end else begin
        pend_v <= 1'b0;
        if (pend_v) tr[pend_sel] <= pend_data;
        if (wr_en && wr_sel != 3'd7) tr[wr_sel] <= wr_data;
        if (pend_v || (wr_en && wr_sel != 3'd7)) begin
          ok_cnt <= '0; fall_done <= 1'b0;
        end
      end
    end

  assign t_sec  = tr[0];
  assign t_min  = tr[1];
  assign t_hour = tr[2];
  assign t_wday = tr[3];
  assign t_mday = tr[4];
  assign t_mon  = tr[5];
  assign t_year = tr[6];

  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> upd_done);  // R9
  AST_DONE_ONLY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(sec_tick));  // R9
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && !cfg_bin) |-> (t_sec[3:0] <= 4'd9 && t_min[3:0] <= 4'd9));  // R2
  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> (t_wday >= 8'd1 && t_wday <= 8'd7));  // R2
  AST_SPRING_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && spring) |=> (c_h == 8'd3 && c_s == 8'd0));  // R5
  AST_NO_DST_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !cfg_dst && !cfg_we && at_159) |=> (c_h == 8'd2));  // R8
endmodule

// File: tb/sim_caltime_step.sv
module sim_caltime_step;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, sec_tick = 0, cfg_we = 0;
  logic cfg_bin_in = 0, cfg_h24_in = 0, cfg_dst_in = 0;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year;
  logic upd_done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  caltime_step u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic cfg(input logic b, input logic h, input logic d);
    @(negedge clk); cfg_we = 1; cfg_bin_in = b; cfg_h24_in = h; cfg_dst_in = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load_date(input logic [7:0] wd, md, mo, yr);
    wr(3, wd); wr(4, md); wr(5, mo); wr(6, yr);
  endtask

  task automatic load_time(input logic [7:0] h, m, s);
    wr(2, h); wr(1, m); wr(0, s);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic t_reset();
    chk("R1 sec", t_sec, 8'h00);   chk("R1 min", t_min, 8'h00);
    chk("R1 hour", t_hour, 8'h00); chk("R1 wday", t_wday, 8'h01);
    chk("R1 mday", t_mday, 8'h01); chk("R1 mon", t_mon, 8'h01);
    chk("R1 year", t_year, 8'h00); chk("R1 done", {7'd0, upd_done}, 8'h00);
  endtask

  task automatic t_bcd_roll();
    cfg(0, 1, 0);
    load_date(8'h07, 8'h31, 8'h12, 8'h99);
    load_time(8'h23, 8'h59, 8'h59);
    tick();
    chk("R9 done high", {7'd0, upd_done}, 8'h01);
    chk("R2 sec", t_sec, 8'h00);   chk("R2 min", t_min, 8'h00);
    chk("R2 hour", t_hour, 8'h00); chk("R2 wday", t_wday, 8'h01);
    chk("R2 mday", t_mday, 8'h01); chk("R2 mon", t_mon, 8'h01);
    chk("R2 year", t_year, 8'h00);
    @(negedge clk);
    chk("R9 done low", {7'd0, upd_done}, 8'h00);
    tick(); chk("R2 sec step", t_sec, 8'h01);
  endtask

  task automatic t_bin_month();
    cfg(1, 1, 0);
    load_date(2, 28, 2, 23); load_time(23, 59, 59); tick();
    chk("R3 feb28 nonleap mday", t_mday, 8'd1); chk("R3 feb28 nonleap mon", t_mon, 8'd3);
    load_date(2, 28, 2, 24); load_time(23, 59, 59); tick();
    chk("R3 leap mday", t_mday, 8'd29); chk("R3 leap mon", t_mon, 8'd2);
    load_time(23, 59, 59); tick();
    chk("R3 feb29 mday", t_mday, 8'd1); chk("R3 feb29 mon", t_mon, 8'd3);
    load_date(5, 30, 4, 24); load_time(23, 59, 59); tick();
    chk("R3 apr30 mday", t_mday, 8'd1); chk("R3 apr30 mon", t_mon, 8'd5);
    load_date(5, 30, 5, 24); load_time(23, 59, 59); tick();
    chk("R3 may30 mday", t_mday, 8'd31);
    load_date(7, 31, 12, 99); load_time(23, 59, 59); tick();
    chk("R3 year wrap", t_year, 8'd0); chk("R3 bin sec", t_sec, 8'd0);
  endtask

  task automatic t_12h();
    cfg(0, 0, 0);
    load_date(8'h03, 8'h10, 8'h05, 8'h20);
    load_time(8'h11, 8'h59, 8'h59); tick(); chk("R4 11am->12pm", t_hour, 8'h92);
    load_time(8'h92, 8'h59, 8'h59); tick(); chk("R4 12pm->1pm", t_hour, 8'h81);
    load_time(8'h91, 8'h59, 8'h59); tick(); chk("R4 11pm->12am", t_hour, 8'h12);
    chk("R4 day advance", t_mday, 8'h11);
    load_time(8'h12, 8'h59, 8'h59); tick(); chk("R4 12am->1am", t_hour, 8'h01);
  endtask

  task automatic t_spring();
    cfg(0, 1, 1);
    load_date(8'h01, 8'h02, 8'h04, 8'h25);
    load_time(8'h01, 8'h59, 8'h57); tick(); tick(); tick();
    chk("R5 jump hour", t_hour, 8'h03); chk("R5 jump min", t_min, 8'h00);
    chk("R5 jump sec", t_sec, 8'h00);
    load_time(8'h01, 8'h59, 8'h58); tick(); tick();
    chk("R7 guard blocks jump", t_hour, 8'h02);
    wr(4, 8'h09);
    load_time(8'h01, 8'h59, 8'h57); tick(); tick(); tick();
    chk("R5 later sunday", t_hour, 8'h02);
  endtask

  task automatic t_dst_off();
    cfg(0, 1, 0);
    load_date(8'h01, 8'h02, 8'h04, 8'h25);
    load_time(8'h01, 8'h59, 8'h57); tick(); tick(); tick();
    chk("R8 no jump", t_hour, 8'h02);
  endtask

  task automatic t_fall();
    cfg(0, 1, 1);
    load_date(8'h01, 8'h29, 8'h10, 8'h25);
    load_time(8'h01, 8'h59, 8'h57); tick(); tick(); tick();
    chk("R6 fall hour", t_hour, 8'h01); chk("R6 fall min", t_min, 8'h00);
    repeat (3599) tick();
    chk("R6 repeat min", t_min, 8'h59); chk("R6 repeat sec", t_sec, 8'h59);
    tick();
    chk("R6 once only", t_hour, 8'h02);
  endtask

  task automatic t_defer();
    cfg(0, 1, 0);
    load_time(8'h05, 8'h00, 8'h10);
    @(negedge clk); sec_tick = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h30;
    @(negedge clk); sec_tick = 0; wr_en = 0;
    chk("R10 update uses old", t_sec, 8'h11);
    @(negedge clk);
    chk("R10 deferred write", t_sec, 8'h30);
  endtask

  task automatic t_cfg_keep();
    cfg(1, 1, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    wr(0, 8'h3B); tick();
    chk("R11 bin sec", t_sec, 8'h00); chk("R11 bin min", t_min, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bcd_roll();
    t_bin_month();
    t_12h();
    t_spring();
    t_dst_off();
    t_fall();
    t_defer();
    t_cfg_keep();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule